// File: doc/BRIEF.md
# Protection Region Address Matcher

This block is a single region slot of a memory protection unit. It holds a base address, a five-bit size code, an enable flag and an eight-bit mask that can remove eighths of the region. For every 32-bit address on its input it reports whether that address lies inside the configured region. It also presents the stored settings to the surrounding logic. Priority between slots, permission decisions and fault capture belong to the logic around it.

The region spans 2^(code+1) bytes, so code 4 gives 32 bytes and code 31 gives the whole 4 GB space. A base that is not aligned to the size is quietly rounded down. Regions of 256 bytes or more are cut into eight equal slices, and each set mask bit removes one slice from the match. Two registers are loaded through a simple write port. The match itself is combinational, and new settings apply from the clock edge that takes the write.

Top module: `prot_region_match`

## Requirements
- R1: After reset the stored base, enable, size code and slice mask are all zero, and `hit_o` is low.
- R2: With `cfg_we` high at a rising clock edge, `cfg_sel`=0 loads the base from `cfg_wdata`. `cfg_sel`=1 loads the attribute word: enable in bit 0, size code in bits 5:1, slice mask in bits 15:8. The new values show on the outputs and on `hit_o` after that edge.
- R3: While the enable bit is 0, `hit_o` is low for every address.
- R4: Size codes 0 to 3 never produce a hit, even when the slot is enabled.
- R5: For code s from 4 to 31 the region covers the half-open range [B, B+2^(s+1)), where B is the effective base. The address B+2^(s+1) is outside the region.
- R6: The effective base `base_o` equals the stored base with bits s:0 cleared. A misaligned base is realigned downward and is not flagged.
- R7: Code 31 matches every 32-bit address, apart from slices removed by the mask.
- R8: For codes 7 and above, the region is split into eight equal slices, and slice 0 holds the lowest addresses. When mask bit n is 1, addresses in slice n do not hit.
- R9: For codes 4 to 6 the slice mask has no effect on `hit_o`.
- R10: `hit_o` follows `addr_i` combinationally, within the same cycle and with no register on the way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Register select: 0 base, 1 attributes |
| cfg_wdata | input | 32 | Configuration write data |
| addr_i | input | 32 | Address to classify |
| hit_o | output | 1 | Address lies inside the enabled region |
| en_o | output | 1 | Stored enable flag |
| size_o | output | 5 | Stored size code |
| srd_o | output | 8 | Stored slice-disable mask |
| base_o | output | 32 | Effective, size-aligned base |

## Verification
A configuration write is due one edge later. The bench applies each write at a falling edge, lets one rising edge pass, and only then reads the stored fields and the effective base. The hit result has no register in its path, so each address is applied and `hit_o` is read 1 ns later within the same cycle, away from any edge. Sweeps over sizes 4 to 12 and size 31 use misaligned bases and several slice masks. They step across each region and its edges, including B-1, B, B+size-1 and B+size, and compare against arithmetic done in 64-bit integers.

// File: rtl/prm_pkg.sv
package prm_pkg;
  localparam int ADDR_W      = 32;
  localparam int SIZE_W      = 5;
  localparam int SR_N        = 8;
  localparam int MIN_CODE    = 4;
  localparam int SR_MIN_CODE = 7;
  localparam int ATTR_EN_BIT = 0;
  localparam int ATTR_SZ_LO  = 1;
  localparam int ATTR_SR_LO  = 8;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic              en;
    logic [SIZE_W-1:0] code;
    logic [SR_N-1:0]   srd;
  } region_cfg_t;
endpackage

// File: rtl/prm_cfg_regs.sv
module prm_cfg_regs
  import prm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output region_cfg_t       cfg_o
);
  region_cfg_t cfg_q, cfg_d;
  logic        base_ld, attr_ld;

  always_comb begin
    base_ld = we_i && !sel_i;
    attr_ld = we_i && sel_i;
    cfg_d   = cfg_q;
    if (base_ld) cfg_d.base = wdata_i;
    if (attr_ld) begin
      cfg_d.en   = wdata_i[ATTR_EN_BIT];
      cfg_d.code = wdata_i[ATTR_SZ_LO +: SIZE_W];
      cfg_d.srd  = wdata_i[ATTR_SR_LO +: SR_N];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cfg_q <= '0;
    else if (we_i) cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;

  // R2
  attr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && sel_i) |=> (cfg_q.en == $past(wdata_i[ATTR_EN_BIT]) &&
                         cfg_q.code == $past(wdata_i[ATTR_SZ_LO +: SIZE_W])));
  // R2
  base_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !sel_i) |=> (cfg_q.base == $past(wdata_i)));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(cfg_q));
endmodule

// File: rtl/prm_mask_gen.sv
module prm_mask_gen
  import prm_pkg::*;
(
  input  logic [SIZE_W-1:0] code_i,
  output logic [ADDR_W-1:0] keep_o
);
  // bit i takes part in the compare only when it lies above bit code
  for (genvar gi = 0; gi < ADDR_W; gi++) begin : g_keep
    assign keep_o[gi] = ({1'b0, code_i} < (SIZE_W+1)'(gi));
  end
endmodule

// File: rtl/prm_subregion.sv
module prm_subregion
  import prm_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] code_i,
  input  logic [SR_N-1:0]   srd_i,
  output logic              excl_o
);
  localparam int IDX_W = $clog2(SR_N);

  logic              active;
  logic [SIZE_W-1:0] sh;
  logic [ADDR_W-1:0] shifted;
  logic [IDX_W-1:0]  idx;

  always_comb begin
    active  = (code_i >= SIZE_W'(SR_MIN_CODE));
    // one slice spans 2^(code+1-IDX_W) bytes
    sh      = code_i - SIZE_W'(IDX_W - 1);
    shifted = addr_i >> sh;
    idx     = shifted[IDX_W-1:0];
    excl_o  = active && srd_i[idx];
  end
endmodule

// File: rtl/prot_region_match.sv
module prot_region_match
  import prm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic [31:0]       addr_i,
  output logic              hit_o,
  output logic              en_o,
  output logic [4:0]        size_o,
  output logic [7:0]        srd_o,
  output logic [31:0]       base_o
);
  region_cfg_t       cfg;
  logic [ADDR_W-1:0] keep;
  logic              excl;
  logic              legal, in_range;

  prm_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .sel_i(cfg_sel),
    .wdata_i(cfg_wdata), .cfg_o(cfg)
  );

  prm_mask_gen u_mask (.code_i(cfg.code), .keep_o(keep));

  prm_subregion u_sub (
    .addr_i(addr_i), .code_i(cfg.code), .srd_i(cfg.srd), .excl_o(excl)
  );

  always_comb begin
    legal    = (cfg.code >= SIZE_W'(MIN_CODE));
    in_range = (((addr_i ^ cfg.base) & keep) == '0);
    hit_o    = cfg.en && legal && in_range && !excl;
  end

  assign en_o   = cfg.en;
  assign size_o = cfg.code;
  assign srd_o  = cfg.srd;
  assign base_o = cfg.base & keep;

  // R3
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_o |-> !hit_o);
  // R4
  small_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (size_o < 5'd4) |-> !hit_o);
  // R6
  base_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((base_o & ~keep) == '0));
  // R5
  hit_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> ((addr_i & keep) == base_o));
  // R8
  slice_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    excl |-> !hit_o);
endmodule

// File: tb/sim_prot_region_match.sv
module sim_prot_region_match;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0, cfg_sel = 0;
  logic [31:0] cfg_wdata = '0, addr_i = '0;
  logic        hit_o, en_o;
  logic [4:0]  size_o;
  logic [7:0]  srd_o;
  logic [31:0] base_o;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  prot_region_match u0 (.*);

  function automatic bit exp_hit(bit en, int s, longint b, longint a, logic [7:0] m);
    longint sz, eb;
    int idx;
    if (!en || s < 4) return 0;
    sz = longint'(1) << (s + 1);
    eb = b & ~(sz - 1);
    if (a < eb || a >= eb + sz) return 0;
    if (s >= 7) begin
      idx = int'((a - eb) / (sz / 8));
      if (m[idx]) return 0;
    end
    return 1;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h addr=%0h", req, act, exp, addr_i);
    end
  endtask

  task automatic wr(bit sel, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic setup(logic [31:0] b, bit en, int s, logic [7:0] m);
    wr(0, b);
    wr(1, {16'h0, m, 2'b00, 5'(s), en});
  endtask

  task automatic probe(string req, bit en, int s, longint b, longint a, logic [7:0] m);
    addr_i = 32'(a);
    #1;
    chk(req, hit_o, exp_hit(en, s, b, a, m));
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] masks [3];
    masks[0] = 8'h00; masks[1] = 8'hA5; masks[2] = 8'h18;
    #22 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    addr_i = 32'h0; #1;
    chk("R1 hit", hit_o, 0);
    chk("R1 cfg", {en_o, size_o, srd_o, base_o}, 0);

    // R3 disabled slot, then R2 enable takes effect after the edge
    setup(32'h2000_0000, 0, 10, 8'h00);
    probe("R3", 0, 10, 32'h2000_0000, 32'h2000_0100, 8'h00);
    chk("R2 size", size_o, 10);
    chk("R2 base", base_o, 32'h2000_0000);
    wr(1, {16'h0, 8'h00, 2'b00, 5'd10, 1'b1});
    probe("R2 en", 1, 10, 32'h2000_0000, 32'h2000_0100, 8'h00);
    // R10 hit changes within the cycle
    addr_i = 32'h2000_0800; #1; chk("R10 out", hit_o, 0);
    addr_i = 32'h2000_07FF; #1; chk("R10 in", hit_o, 1);

    // R4 small codes never hit
    for (int s = 0; s < 4; s++) begin
      setup(32'h0000_0000, 1, s, 8'h00);
      for (int a = 0; a < 64; a += 3) probe("R4", 1, s, 0, a, 8'h00);
    end

    // R5 R6 R8 R9 sweeps with misaligned bases
    for (int s = 4; s <= 12; s++) begin
      for (int mi = 0; mi < 3; mi++) begin
        longint sz, eb, stp;
        logic [31:0] b;
        b  = 32'h2000_1000 | (32'h1 << (s - 1)) | 32'h3;
        sz = longint'(1) << (s + 1);
        eb = longint'(b) & ~(sz - 1);
        stp = (sz >= 32) ? sz / 32 : 1;
        setup(b, 1, s, masks[mi]);
        chk("R6 base", base_o, eb);
        chk("R2 srd", srd_o, masks[mi]);
        probe("R5 below", 1, s, b, eb - 1, masks[mi]);
        probe("R5 last", 1, s, b, eb + sz - 1, masks[mi]);
        probe("R5 end", 1, s, b, eb + sz, masks[mi]);
        for (longint a = eb - sz / 4; a <= eb + sz + sz / 4; a += stp)
          probe(s >= 7 ? "R8" : "R9", 1, s, b, a, masks[mi]);
      end
    end

    // R7 whole space, with and without a removed slice
    for (int mi = 0; mi < 2; mi++) begin
      logic [7:0] m;
      m = (mi == 0) ? 8'h00 : 8'h81;
      setup(32'h1234_5678, 1, 31, m);
      chk("R7 base", base_o, 0);
      for (longint a = 0; a < 64'h1_0000_0000; a += 64'h0FFF_FFF1)
        probe("R7", 1, 31, 32'h1234_5678, a, m);
      probe("R7 top", 1, 31, 32'h1234_5678, 64'hFFFF_FFFF, m);
      probe("R8 s31", 1, 31, 32'h1234_5678, 64'h2000_0000, m);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule